// File: doc/BRIEF.md
# Oversampled Serial Receiver with Idle-Line and Wakeup Handling

This block is the receiving side of an asynchronous serial link. It takes the raw serial input and a one-cycle sample enable that runs at sixteen times the bit rate. Each character is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block votes three mid-bit samples to get each bit value, builds the character in a shift register, and moves the finished character into a holding register that the host reads. Together with the character it records three error conditions: noise, overrun and framing.

The block finds idle periods on the line. An idle flag is raised only when a good character has arrived since the last idle report. It also has a sleep state for multi-drop links. While asleep, received traffic is thrown away until one of two selected events wakes the receiver: a quiet line, or a character whose top bit is set. A single read strobe clears every status flag. One interrupt output combines the receive-full and idle conditions, each with its own enable.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_full`, `err_ovr`, `err_noise`, `err_frame`, `line_idle`, `asleep` and `irq` are all 0.
- R2: A frame made of a 0 start bit, DATA_W data bits least significant first and a 1 stop bit, each held for OVS sample ticks, appears on `rx_data` with `rx_full` set.
- R3: When a character completes while `rx_full` is still set, `err_ovr` sets, the new character is discarded and `rx_data` keeps the older byte.
- R4: Each bit value is the majority of the samples at ticks OVS/2-1, OVS/2 and OVS/2+1 of the bit. If any of these disagree in any bit of a transferred character, `err_noise` is set for that character.
- R5: When the voted stop bit is 0, the character is still transferred and `err_frame` is set.
- R6: A one-cycle pulse on `rd_clr` clears `rx_full`, `err_ovr`, `err_noise`, `err_frame` and `line_idle`. A flag being set in the same cycle takes priority over the clear.
- R7: `line_idle` sets after OVS*(DATA_W+2) consecutive high samples, but only when a character with a good stop bit has been transferred since the last idle report. A second idle period with no new character leaves it at 0.
- R8: `irq` is high exactly when (`rx_full` and `full_ie`) or (`line_idle` and `idle_ie`).
- R9: While `asleep` is 1, characters are not transferred and `line_idle` does not set.
- R10: With `wake_on_addr` = 0, a full idle-line period while asleep clears `asleep`.
- R11: With `wake_on_addr` = 1, a character whose most significant bit is 1 clears `asleep` and is transferred. A character whose most significant bit is 0 is dropped and the receiver stays asleep.
- R12: While `rx_en` is 0, incoming frames are ignored and `rx_full` stays 0.
- R13: A start edge whose voted start bit is 1 is treated as a false start. Nothing is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable, OVS pulses per bit time |
| rxd | input | 1 | Serial input, idles high |
| rx_en | input | 1 | Receiver enable |
| full_ie | input | 1 | Interrupt enable for receive-full |
| idle_ie | input | 1 | Interrupt enable for idle line |
| wake_on_addr | input | 1 | Wake method: 0 idle line, 1 character with top bit set |
| sleep_req | input | 1 | One-cycle pulse that puts the receiver to sleep |
| rd_clr | input | 1 | Read strobe that clears the status flags |
| rx_data | output | DATA_W | Last transferred character |
| rx_full | output | 1 | Receive data register full |
| err_ovr | output | 1 | Overrun error |
| err_noise | output | 1 | Noise error |
| err_frame | output | 1 | Framing error |
| line_idle | output | 1 | Idle line detected |
| asleep | output | 1 | Wakeup mode active |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and OVS = 16. This puts the voting window at ticks 7 to 9 and the idle window at 160 ticks. The sample enable fires on every second clock, so the stall path of the tick enable is exercised on every bit. A one-tick glitch placed at tick 9 of a data bit lands inside the voting window whatever the synchronizer phase. A low stop bit held for the full bit time also drives a false start, so both the framing path and the false-start path are reached from a single frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [0:0] {
    FR_WAIT = 1'b0,
    FR_BITS = 1'b1
  } fr_state_t;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // high when the three samples are not all equal
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rxs,
  output logic              chr_done,
  output logic [DATA_W-1:0] chr_data,
  output logic              chr_noise,
  output logic              chr_ferr
);
  localparam int PH_W   = $clog2(OVS);
  localparam int IDX_W  = $clog2(DATA_W + 2);
  localparam int S0     = OVS / 2 - 1;
  localparam int S1     = OVS / 2;
  localparam int S2     = OVS / 2 + 1;
  localparam int STOP_I = DATA_W + 1;

  fr_state_t          state;
  logic [PH_W-1:0]    phase;
  logic [IDX_W-1:0]   bit_idx;
  logic [1:0]         samp;
  logic [DATA_W-1:0]  shreg;
  logic               noise_acc;

  logic               bit_val;
  logic               bit_split;
  logic               at_vote;

  assign bit_val   = vote3(samp[0], samp[1], rxs);
  assign bit_split = split3(samp[0], samp[1], rxs);
  assign at_vote   = (state == FR_BITS) && tick && (phase == PH_W'(S2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FR_WAIT;
      phase     <= '0;
      bit_idx   <= '0;
      samp      <= '0;
      shreg     <= '0;
      noise_acc <= 1'b0;
      chr_done  <= 1'b0;
      chr_data  <= '0;
      chr_noise <= 1'b0;
      chr_ferr  <= 1'b0;
    end else begin
      chr_done <= 1'b0;
      if (!en) begin
        state <= FR_WAIT;
      end else if (tick) begin
        case (state)
          FR_WAIT: begin
            if (!rxs) begin
              state     <= FR_BITS;
              phase     <= PH_W'(1);
              bit_idx   <= '0;
              noise_acc <= 1'b0;
            end
          end
          FR_BITS: begin
            if (phase == PH_W'(S0)) samp[0] <= rxs;
            if (phase == PH_W'(S1)) samp[1] <= rxs;
            if (phase == PH_W'(OVS - 1)) begin
              phase   <= '0;
              bit_idx <= bit_idx + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
            if (phase == PH_W'(S2)) begin
              if (bit_idx == '0) begin
                if (bit_val) state <= FR_WAIT;
                else         noise_acc <= bit_split;
              end else if (bit_idx == IDX_W'(STOP_I)) begin
                state     <= FR_WAIT;
                chr_done  <= 1'b1;
                chr_data  <= shreg;
                chr_noise <= noise_acc | bit_split;
                chr_ferr  <= ~bit_val;
              end else begin
                shreg     <= {bit_val, shreg[DATA_W-1:1]};
                noise_acc <= noise_acc | bit_split;
              end
            end
          end
          default: state <= FR_WAIT;
        endcase
      end
    end
  end

  // R2: a completed character is a single-cycle event
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |=> !chr_done);

  // R13: a high vote on the start bit never completes a character next cycle
  p_false_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (at_vote && bit_idx == '0 && bit_val) |=> !chr_done && state == FR_WAIT);

  // R5: framing flag of a completed character reflects the stop vote
  p_stop_vote_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_vote && en && bit_idx == IDX_W'(STOP_I)) |=> chr_done && (chr_ferr == !$past(bit_val)));
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxs,
  output logic idle_hit
);
  localparam int IDLE_TICKS = OVS * (DATA_W + 2);
  localparam int CNT_W      = $clog2(IDLE_TICKS + 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (tick) begin
        if (!rxs) begin
          run_cnt <= '0;
        end else if (run_cnt != CNT_W'(IDLE_TICKS)) begin
          run_cnt <= run_cnt + 1'b1;
          if (run_cnt == CNT_W'(IDLE_TICKS - 1)) idle_hit <= 1'b1;
        end
      end
    end
  end

  // R7: an idle report is only produced after a high sample
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> $past(rxs));

  // R7: a saturated run reports once
  p_idle_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> !idle_hit);
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              full_ie,
  input  logic              idle_ie,
  input  logic              wake_on_addr,
  input  logic              sleep_req,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_ovr,
  output logic              err_noise,
  output logic              err_frame,
  output logic              line_idle,
  output logic              asleep,
  output logic              irq
);
  logic              rxs;
  logic              chr_done;
  logic [DATA_W-1:0] chr_data;
  logic              chr_noise;
  logic              chr_ferr;
  logic              idle_hit;
  logic              armed;

  logic              addr_mark;
  logic              accept;
  logic              full_busy;
  logic              xfer;
  logic              ovr_set;
  logic              idle_set;
  logic              wake_evt;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .en(rx_en), .rxs(rxs),
    .chr_done(chr_done), .chr_data(chr_data),
    .chr_noise(chr_noise), .chr_ferr(chr_ferr)
  );

  rx_idle_det #(.DATA_W(DATA_W), .OVS(OVS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxs(rxs), .idle_hit(idle_hit)
  );

  assign addr_mark = chr_data[DATA_W-1];
  assign accept    = chr_done && rx_en && (!asleep || (wake_on_addr && addr_mark));
  assign full_busy = rx_full && !rd_clr;
  assign xfer      = accept && !full_busy;
  assign ovr_set   = accept && full_busy;
  assign idle_set  = idle_hit && armed && !asleep && rx_en;
  assign wake_evt  = asleep && ((chr_done && rx_en && wake_on_addr && addr_mark) ||
                                (idle_hit && !wake_on_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_full   <= 1'b0;
      err_ovr   <= 1'b0;
      err_noise <= 1'b0;
      err_frame <= 1'b0;
      line_idle <= 1'b0;
      asleep    <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (xfer) begin
        rx_data   <= chr_data;
        rx_full   <= 1'b1;
        err_noise <= chr_noise;
        err_frame <= chr_ferr;
      end else if (rd_clr) begin
        rx_full   <= 1'b0;
        err_noise <= 1'b0;
        err_frame <= 1'b0;
      end

      if (ovr_set)     err_ovr <= 1'b1;
      else if (rd_clr) err_ovr <= 1'b0;

      if (idle_set)    line_idle <= 1'b1;
      else if (rd_clr) line_idle <= 1'b0;

      if (idle_set)                armed <= 1'b0;
      else if (xfer && !chr_ferr)  armed <= 1'b1;

      if (sleep_req)     asleep <= 1'b1;
      else if (wake_evt) asleep <= 1'b0;
    end
  end

  assign irq = (rx_full && full_ie) || (line_idle && idle_ie);

  // R3: an overrun leaves the held byte untouched
  p_ovr_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && rx_full && !rd_clr) |=> $stable(rx_data) && err_ovr);

  // R6: a clear with no concurrent event empties every flag
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !chr_done && !idle_hit) |=>
      !rx_full && !err_ovr && !err_noise && !err_frame && !line_idle);

  // R7: the idle flag cannot rise while unarmed
  p_idle_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !line_idle) |=> !line_idle);

  // R9: a sleeping receiver in idle-wake mode takes no character
  p_no_xfer_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && asleep && !wake_on_addr && !rx_full) |=> !rx_full);

  // R10 / R11: leaving sleep follows a character or an idle report
  p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(chr_done || idle_hit));

  // R12: disabled receiver never fills
  p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_full) |=> !rx_full);
endmodule

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int DW         = 8;
  localparam int OV         = 16;
  localparam int IDLE_T     = OV * (DW + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16;
  logic rxd = 1'b1;
  logic rx_en = 1'b1;
  logic full_ie = 1'b0;
  logic idle_ie = 1'b0;
  logic wake_on_addr = 1'b0;
  logic sleep_req = 1'b0;
  logic rd_clr = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_full, err_ovr, err_noise, err_frame, line_idle, asleep, irq;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
  assign tick16 = (tcnt == 0);

  serial_rx_top #(.DATA_W(DW), .OVS(OV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .full_ie(full_ie), .idle_ie(idle_ie), .wake_on_addr(wake_on_addr),
    .sleep_req(sleep_req), .rd_clr(rd_clr), .rx_data(rx_data),
    .rx_full(rx_full), .err_ovr(err_ovr), .err_noise(err_noise),
    .err_frame(err_frame), .line_idle(line_idle), .asleep(asleep), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  // glitch_bit: index of frame bit (0 start, 1..DW data, DW+1 stop) with a one-tick flip at tick 9; -1 none
  task automatic send_frame(input logic [DW-1:0] d, input logic stop_v, input int glitch_bit);
    for (int b = 0; b < DW + 2; b++) begin
      logic lvl;
      lvl = (b == 0) ? 1'b0 : (b == DW + 1) ? stop_v : d[b-1];
      for (int t = 0; t < OV; t++) begin
        rxd = (b == glitch_bit && t == 9) ? ~lvl : lvl;
        wait_ticks(1);
      end
    end
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  task automatic pulse_clr();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 rx_data", int'(rx_data), 0);
    check("R1 flags", int'({rx_full, err_ovr, err_noise, err_frame, line_idle, asleep, irq}), 0);
  endtask

  task automatic t_idle_unarmed();
    wait_ticks(IDLE_T + 20);
    check("R7 no idle before any character", int'(line_idle), 0);
  endtask

  task automatic t_basic();
    send_frame(8'h5A, 1'b1, -1);
    check("R2 data", int'(rx_data), 'h5A);
    check("R2 full", int'(rx_full), 1);
    check("R2 clean errors", int'({err_ovr, err_noise, err_frame}), 0);
    full_ie = 1'b1; @(negedge clk);
    check("R8 irq full", int'(irq), 1);
    full_ie = 1'b0; @(negedge clk);
    check("R8 irq masked", int'(irq), 0);
    pulse_clr();
    check("R6 full cleared", int'(rx_full), 0);
  endtask

  task automatic t_idle();
    wait_ticks(IDLE_T + 20);
    check("R7 idle after character", int'(line_idle), 1);
    idle_ie = 1'b1; @(negedge clk);
    check("R8 irq idle", int'(irq), 1);
    pulse_clr();
    check("R6 idle cleared", int'(line_idle), 0);
    check("R8 irq after clear", int'(irq), 0);
    idle_ie = 1'b0;
    rxd = 1'b0; wait_ticks(2); rxd = 1'b1;   // short glitch restarts idle run; voted start high
    wait_ticks(IDLE_T + 20);
    check("R7 idle not rearmed", int'(line_idle), 0);
    check("R13 glitch not a character", int'(rx_full), 0);
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 1'b1, -1);
    send_frame(8'h22, 1'b1, -1);
    check("R3 overrun flag", int'(err_ovr), 1);
    check("R3 older data kept", int'(rx_data), 'h11);
    pulse_clr();
    check("R6 all cleared", int'({rx_full, err_ovr, err_noise, err_frame}), 0);
  endtask

  task automatic t_noise();
    send_frame(8'hC3, 1'b1, 4);
    check("R4 majority data", int'(rx_data), 'hC3);
    check("R4 noise flag", int'(err_noise), 1);
    check("R4 no framing", int'(err_frame), 0);
    pulse_clr();
  endtask

  task automatic t_framing();
    send_frame(8'h3C, 1'b0, -1);
    check("R5 framing flag", int'(err_frame), 1);
    check("R5 data", int'(rx_data), 'h3C);
    pulse_clr();
    wait_ticks(30);
    check("R13 no false character", int'(rx_full), 0);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send_frame(8'h77, 1'b1, -1);
    check("R12 ignored while disabled", int'(rx_full), 0);
    rx_en = 1'b1;
    wait_ticks(2);
  endtask

  task automatic t_wake_idle();
    wake_on_addr = 1'b0;
    pulse_sleep();
    check("R9 asleep set", int'(asleep), 1);
    send_frame(8'h44, 1'b1, -1);
    check("R9 no transfer asleep", int'(rx_full), 0);
    check("R10 still asleep after char", int'(asleep), 1);
    wait_ticks(IDLE_T + 20);
    check("R10 idle line wakes", int'(asleep), 0);
    check("R9 idle suppressed asleep", int'(line_idle), 0);
  endtask

  task automatic t_wake_addr();
    wake_on_addr = 1'b1;
    pulse_sleep();
    send_frame(8'h35, 1'b1, -1);
    check("R11 msb0 dropped", int'(rx_full), 0);
    check("R11 still asleep", int'(asleep), 1);
    send_frame(8'hA7, 1'b1, -1);
    check("R11 msb1 wakes", int'(asleep), 0);
    check("R11 msb1 transferred", int'(rx_data), 'hA7);
    check("R11 full", int'(rx_full), 1);
    pulse_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_unarmed();
    t_basic();
    t_idle();
    t_overrun();
    t_noise();
    t_framing();
    t_disabled();
    t_wake_idle();
    t_wake_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule